// File: doc/BRIEF.md
# Write Leveling Feedback Responder

This block models the memory-device side of DDR3 write leveling so that a memory controller's leveling engine can be tested against synthesizable logic. It watches the command/address inputs for mode register writes to MR1. When the leveling bit is set, the block enters leveling mode and turns its data output enable on. When the bit is cleared, the block leaves leveling mode.

While leveling is active and termination is on (`odt` high), each rising edge of the data strobe takes a sample of the memory clock level. That sample is returned on the DQ bus after a fixed number of cycles. A static select chooses between two lane patterns. In one, every lane carries the sample. In the other, only the prime lane carries it and every other lane is held low.

After the exit write, the DQ bus is treated as undefined for a fixed number of cycles. During that window the output enable is off and a flag marks the window. All inputs are sampled on a fast local clock `clk`. A strobe rising edge is a low-to-high change between two successive samples of `dqs`.

Top module: `wrlvl_responder`

## Requirements
- R1: While `rst_n` is low, and after reset until the first command, `dq_oe`, `dq_undef` and every bit of `dq` are 0.
- R2: A mode register write (`cs_n`, `ras_n`, `cas_n`, `we_n` all 0) with `ba` = 1 and `addr[7]` = 1 sets `dq_oe` to 1 after that clock edge.
- R3: A mode register write to any other bank, and any other command, leaves the mode unchanged.
- R4: While leveling is already active and `odt` is 1, the edge at which `dqs` is first seen high after being seen low captures `ck_lvl`. The captured value shows on the driven lanes exactly WLO_LAT clock edges later.
- R5: The feedback value holds between strobe rising edges. A strobe held high, or clock-level changes without a strobe rise, leave `dq` unchanged.
- R6: With `all_lanes` = 1, every bit of `dq` equals the feedback value. With `all_lanes` = 0, bit PRIME_LANE carries the feedback value and every other bit is 0.
- R7: A mode register write with `ba` = 1 and `addr[7]` = 0 during leveling clears `dq_oe` after that edge. It also raises `dq_undef` for exactly MOD_CYC cycles, during which `dq` is 0.
- R8: Outside leveling mode, strobe edges are ignored. `dq_oe` stays 0, and after re-entry the feedback starts from 0.
- R9: While `odt` is 0, strobe rising edges do not update the feedback value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all inputs and state |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command bit, active low |
| cas_n | input | 1 | Column strobe command bit, active low |
| we_n | input | 1 | Write enable command bit, active low |
| ba | input | BAW | Bank address; selects the mode register |
| addr | input | AW | Address bus; bit 7 is the leveling enable in MR1 |
| dqs | input | 1 | Sampled data strobe |
| ck_lvl | input | 1 | Current level of the memory clock |
| odt | input | 1 | Termination enable; gates captures |
| all_lanes | input | 1 | 1: feedback on every lane; 0: prime lane only |
| dq | output | DQ_W | Feedback data lanes |
| dq_oe | output | 1 | Output enable for `dq` |
| dq_undef | output | 1 | High during the post-exit undefined window |

## Verification
A mode write changes `dq_oe` and `dq_undef` right after the edge that samples it. A strobe rise captured at edge N reaches `dq` after edge N+WLO_LAT. `dq_undef` stays high after the exit edge and for MOD_CYC edges in total. The bench keeps a behavioural reference that updates at each rising edge from the same input values the design sees. That reference keeps a queue of feedback values that is WLO_LAT+1 entries long. Inputs change only on falling edges, and at every falling edge the three outputs are compared with the reference, so each result is checked in the very cycle it is due.

// File: rtl/wrlvl_pkg.sv
package wrlvl_pkg;
  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam int MR1_SEL = 1;
  localparam int LVL_BIT = 7;

  function automatic logic cmd_is_mrs(cmd_t c);
    return ~(c.cs_n | c.ras_n | c.cas_n | c.we_n);
  endfunction
endpackage

// File: rtl/wrlvl_cmd_dec.sv
module wrlvl_cmd_dec #(
  parameter int AW  = 14,
  parameter int BAW = 3
) (
  input  wrlvl_pkg::cmd_t  cmd,
  input  logic [BAW-1:0]   ba,
  input  logic [AW-1:0]    addr,
  output logic             lvl_on,
  output logic             lvl_off
);
  logic mr1_wr;

  always_comb begin
    mr1_wr  = wrlvl_pkg::cmd_is_mrs(cmd) && (ba == BAW'(wrlvl_pkg::MR1_SEL));
    lvl_on  = mr1_wr &  addr[wrlvl_pkg::LVL_BIT];
    lvl_off = mr1_wr & ~addr[wrlvl_pkg::LVL_BIT];
  end
endmodule

// File: rtl/wrlvl_mode_ctrl.sv
module wrlvl_mode_ctrl #(
  parameter int MOD_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_on,
  input  logic lvl_off,
  output logic active,
  output logic undef
);
  localparam int CW = $clog2(MOD_CYC + 1);

  logic          active_q, active_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    active_n = active_q;
    cnt_n    = cnt_q;
    if (lvl_on) begin
      active_n = 1'b1;
      cnt_n    = '0;
    end else if (lvl_off && active_q) begin
      active_n = 1'b0;
      cnt_n    = CW'(MOD_CYC);
    end else if (cnt_q != '0) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_n;
      cnt_q    <= cnt_n;
    end
  end

  assign active = active_q;
  assign undef  = (cnt_q != '0);
endmodule

// File: rtl/wrlvl_fb_pipe.sv
module wrlvl_fb_pipe #(
  parameter int WLO_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic odt,
  input  logic dqs,
  input  logic ck_lvl,
  output logic fb_out
);
  logic               dqs_q;
  logic               cap_en;
  logic               fb_n;
  logic [WLO_LAT:0]   dly_q;

  always_comb begin
    cap_en = active & odt & dqs & ~dqs_q;
    if (!active)     fb_n = 1'b0;
    else if (cap_en) fb_n = ck_lvl;
    else             fb_n = dly_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqs_q <= 1'b0;
      dly_q <= '0;
    end else begin
      dqs_q    <= dqs;
      dly_q[0] <= fb_n;
      for (int i = 1; i <= WLO_LAT; i++) begin
        dly_q[i] <= dly_q[i-1];
      end
    end
  end

  assign fb_out = dly_q[WLO_LAT];
endmodule

// File: rtl/wrlvl_responder.sv
module wrlvl_responder #(
  parameter int DQ_W       = 8,
  parameter int PRIME_LANE = 0,
  parameter int AW         = 14,
  parameter int BAW        = 3,
  parameter int WLO_LAT    = 4,
  parameter int MOD_CYC    = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BAW-1:0]  ba,
  input  logic [AW-1:0]   addr,
  input  logic            dqs,
  input  logic            ck_lvl,
  input  logic            odt,
  input  logic            all_lanes,
  output logic [DQ_W-1:0] dq,
  output logic            dq_oe,
  output logic            dq_undef
);
  wrlvl_pkg::cmd_t cmd;
  logic            lvl_on, lvl_off;
  logic            active;
  logic            fb_out;

  assign cmd = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};

  wrlvl_cmd_dec #(.AW(AW), .BAW(BAW)) u_dec (
    .cmd     (cmd),
    .ba      (ba),
    .addr    (addr),
    .lvl_on  (lvl_on),
    .lvl_off (lvl_off)
  );

  wrlvl_mode_ctrl #(.MOD_CYC(MOD_CYC)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_on  (lvl_on),
    .lvl_off (lvl_off),
    .active  (active),
    .undef   (dq_undef)
  );

  wrlvl_fb_pipe #(.WLO_LAT(WLO_LAT)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .odt     (odt),
    .dqs     (dqs),
    .ck_lvl  (ck_lvl),
    .fb_out  (fb_out)
  );

  for (genvar g = 0; g < DQ_W; g++) begin : g_lane
    if (g == PRIME_LANE) begin : g_prime
      assign dq[g] = active & fb_out;
    end else begin : g_other
      assign dq[g] = active & all_lanes & fb_out;
    end
  end

  assign dq_oe = active;
endmodule

// File: rtl/wrlvl_responder_chk.sv
module wrlvl_responder_chk #(
  parameter int DQ_W       = 8,
  parameter int PRIME_LANE = 0,
  parameter int BAW        = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic [BAW-1:0]  ba,
  input logic            wl_bit,
  input logic            all_lanes,
  input logic [DQ_W-1:0] dq,
  input logic            dq_oe,
  input logic            dq_undef
);
  logic mrs_seen;
  logic mr1_seen;
  assign mrs_seen = !cs_n && !ras_n && !cas_n && !we_n;
  assign mr1_seen = mrs_seen && (ba == BAW'(1));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!dq_oe && !dq_undef && dq == '0));

  // R2
  enter_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mr1_seen && wl_bit) |=> dq_oe);

  // R3
  other_cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mr1_seen |=> $stable(dq_oe));

  // R6
  prime_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_lanes |-> ((dq & ~(DQ_W'(1) << PRIME_LANE)) == '0));

  // R6
  all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_lanes |-> (dq == '0 || dq == '1));

  // R7
  exit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && mr1_seen && !wl_bit) |=> (!dq_oe && dq_undef));

  // R7
  undef_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_undef |-> (!dq_oe && dq == '0));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq == '0));
endmodule

bind wrlvl_responder wrlvl_responder_chk #(
  .DQ_W(DQ_W), .PRIME_LANE(PRIME_LANE), .BAW(BAW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .wl_bit(addr[wrlvl_pkg::LVL_BIT]),
  .all_lanes(all_lanes), .dq(dq), .dq_oe(dq_oe), .dq_undef(dq_undef)
);

// File: tb/wrlvl_responder_tb.sv
`timescale 1ns/1ps
module wrlvl_responder_tb;
  localparam int DQ_W = 8, PRIME = 0, AW = 14, BAW = 3, WLO = 4, MODC = 12;

  logic clk = 1'b0;
  logic rst_n, cs_n, ras_n, cas_n, we_n, dqs, ck_lvl, odt, all_lanes;
  logic [BAW-1:0]  ba;
  logic [AW-1:0]   addr;
  logic [DQ_W-1:0] dq;
  logic            dq_oe, dq_undef;

  always #2 clk = ~clk;

  wrlvl_responder #(.DQ_W(DQ_W), .PRIME_LANE(PRIME), .AW(AW), .BAW(BAW),
                    .WLO_LAT(WLO), .MOD_CYC(MODC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .dqs(dqs), .ck_lvl(ck_lvl), .odt(odt),
    .all_lanes(all_lanes), .dq(dq), .dq_oe(dq_oe), .dq_undef(dq_undef));

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model
  bit m_active, m_dqs_prev, m_fb;
  int m_cnt;
  bit fbq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_active = 0; m_dqs_prev = 0; m_fb = 0; m_cnt = 0;
      fbq.delete();
      for (int i = 0; i <= WLO; i++) fbq.push_back(1'b0);
    end else begin
      bit mr1, rise;
      mr1  = !cs_n && !ras_n && !cas_n && !we_n && (ba == 1);
      rise = dqs && !m_dqs_prev;
      if (!m_active) m_fb = 0;
      else if (rise && odt) m_fb = ck_lvl;
      if (mr1 && addr[7]) begin
        m_active = 1; m_cnt = 0;
      end else if (mr1 && !addr[7] && m_active) begin
        m_active = 0; m_cnt = MODC;
      end else if (m_cnt > 0) begin
        m_cnt--;
      end
      m_dqs_prev = dqs;
      fbq.push_back(m_fb);
      void'(fbq.pop_front());
    end
  end

  function automatic logic [DQ_W-1:0] exp_dq();
    logic [DQ_W-1:0] v;
    v = '0;
    if (m_active) begin
      if (all_lanes) v = {DQ_W{fbq[0]}};
      else v[PRIME] = fbq[0];
    end
    return v;
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check("dq", 32'(dq), 32'(exp_dq()));
    check("dq_oe", 32'(dq_oe), 32'(m_active));
    check("dq_undef", 32'(dq_undef), 32'(m_cnt != 0));
  endtask

  task automatic nop();
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = '0; addr = '0;
  endtask

  task automatic mrs(logic [BAW-1:0] b, logic wl);
    cs_n = 0; ras_n = 0; cas_n = 0; we_n = 0; ba = b; addr = '0; addr[7] = wl;
    tick();
    nop();
  endtask

  task automatic strobe(int n, int seed);
    for (int i = 0; i < n; i++) begin
      ck_lvl = ((seed >> (i % 7)) & 1) != 0;
      dqs = 1; tick();
      tick();
      dqs = 0; tick();
      ck_lvl = ~ck_lvl; tick();
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; nop(); dqs = 0; ck_lvl = 0; odt = 0; all_lanes = 0;
    cur_req = "R1";
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R3: other bank, other commands; R8: strobes while idle
    cur_req = "R3";
    mrs(3'd0, 1'b1);
    mrs(3'd2, 1'b1);
    cs_n = 0; ras_n = 0; cas_n = 1; we_n = 1; ba = 3'd1; addr = '1; tick(); nop();
    cs_n = 1; ras_n = 0; cas_n = 0; we_n = 0; ba = 3'd1; addr = '1; tick(); nop();
    cur_req = "R8";
    odt = 1; strobe(3, 8'h5b);

    // R2: enter
    cur_req = "R2";
    mrs(3'd1, 1'b1);
    tick();

    // R4 / R6 prime-only
    cur_req = "R4";
    strobe(10, 8'h6d);
    repeat (WLO + 1) tick();

    // R5: held strobe, clock toggling without a rise
    cur_req = "R5";
    dqs = 1; ck_lvl = 1; tick(); tick();
    for (int i = 0; i < 12; i++) begin ck_lvl = ~ck_lvl; tick(); end
    dqs = 0; repeat (WLO + 2) tick();

    // R9: termination off
    cur_req = "R9";
    odt = 0; strobe(6, 8'h33);
    odt = 1;

    // R6: all lanes
    cur_req = "R6";
    all_lanes = 1;
    strobe(10, 8'h4e);
    repeat (WLO + 1) tick();

    // R3 while active: non-MR1 write keeps mode
    cur_req = "R3";
    mrs(3'd2, 1'b0);
    strobe(2, 8'h7f);

    // R7: exit and window
    cur_req = "R7";
    mrs(3'd1, 1'b0);
    strobe(2, 8'h55);
    repeat (MODC + 4) tick();
    mrs(3'd1, 1'b0);
    repeat (3) tick();

    // R8: re-entry after idle strobes starts from 0
    cur_req = "R8";
    strobe(3, 8'h7f);
    mrs(3'd1, 1'b1);
    repeat (WLO + 2) tick();
    all_lanes = 0;
    strobe(4, 8'h2f);
    repeat (WLO + 1) tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule